// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block keeps one tag word and three status flags for every line of a cache. An address picks one entry. Reads of either field are combinational from the address. The tag field and the status field each have their own write enable and their own output enable. Writes take effect on the rising clock edge. A built-in comparator checks the incoming tag against the stored tag at the addressed entry and raises a hit flag. In dedicated mode the stored valid flag qualifies the hit. In generic mode the three flags are user-defined and do not affect the hit.

Two chip selects, one active low and one active high, let several stores share an address range. A synchronous active-low clear wipes the status flags of every entry on a single clock edge. This invalidates the whole store without walking the addresses, and the tags themselves are kept. The depth is a parameter and is kept small for simulation.

Top module: `cache_tag_store`

## Requirements
- R1: A tag written while selected with `tagWeN` low is stored at `addr` on the rising edge. It appears on `tagOut` as soon as a tag read is set up (selected, `tagOeN` low, `tagWeN` high).
- R2: A status write (selected, `statWeN` low) stores `statIn` at `addr` on the rising edge. Bit 0 is valid, bit 1 is dirty and bit 2 is write-through. The stored value is visible on `statOut` while selected with `statOeN` low and `statWeN` high.
- R3: The tag write leaves the status flags of the entry unchanged, and the status write leaves the stored tag unchanged.
- R4: `clearN` low at a rising edge zeroes all three status flags of every entry, whether or not the block is selected. Stored tags are kept. If a status write falls on the same edge, the clear wins.
- R5: The block is selected only when `cs1N` is low and `cs2` is high. While deselected, all three output-enable flags are low, `matchOut` is low, and no tag or status write takes effect.
- R6: `matchOutEn` equals the select condition. `matchOut` is high only in a compare cycle (selected, `tagOeN` high, `tagWeN` and `statWeN` high) where `tagIn` equals the stored tag and the valid qualification of R8 is met.
- R7: `matchOut` is low during a tag read, a tag write or a status write, even when the tags are equal.
- R8: With `modeGeneric` low, a stored valid flag of 0 forces `matchOut` low. With `modeGeneric` high, the valid flag is ignored.
- R9: `tagOutEn` is high only when selected with `tagOeN` low and `tagWeN` high, and `statOutEn` is high only when selected with `statOeN` low and `statWeN` high. An undriven data output reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clear act on its rising edge |
| clearN | input | 1 | Synchronous clear of all status flags, active low |
| cs1N | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| modeGeneric | input | 1 | 0: valid flag qualifies the hit; 1: flags are generic |
| tagWeN | input | 1 | Tag field write enable, active low |
| statWeN | input | 1 | Status field write enable, active low |
| tagOeN | input | 1 | Tag field output enable, active low |
| statOeN | input | 1 | Status field output enable, active low |
| addr | input | ADDR_W | Entry address |
| tagIn | input | TAG_W | Tag to write or to compare |
| statIn | input | 3 | Status flags to write {write-through, dirty, valid} |
| tagOut | output | TAG_W | Stored tag at addr when driven, else zero |
| tagOutEn | output | 1 | Tag output driven (stands in for high impedance when low) |
| statOut | output | 3 | Stored flags at addr when driven, else zero |
| statOutEn | output | 1 | Status output driven |
| matchOut | output | 1 | Hit flag, active high |
| matchOutEn | output | 1 | Hit output driven |

## Verification
A corrupted tag or a lost flag cannot be seen on the ports until that entry is addressed again. It then shows combinationally, in the same cycle, on `tagOut`, on `statOut` or as a wrong hit. The bench therefore keeps a behavioural copy of every entry and compares all outputs on every cycle. It revisits entries after writes to the other field, after deselected writes and after a clear that collides with a status write. A wrong enable decode shows at once on the enable flags or on `matchOut` during read and write cycles.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;

  localparam int STAT_W  = 3;
  localparam int VLD_BIT = 0;

  typedef struct packed {
    logic tagWr;
    logic statWr;
    logic clearAll;
    logic tagDrive;
    logic statDrive;
    logic matchDrive;
    logic cmpEn;
    logic qualValid;
  } strobes_t;

endpackage

// File: rtl/tag_store_ctrl.sv
module tag_store_ctrl
  import tag_store_pkg::*;
(
  input  logic     clearN,
  input  logic     cs1N,
  input  logic     cs2,
  input  logic     modeGeneric,
  input  logic     tagWeN,
  input  logic     statWeN,
  input  logic     tagOeN,
  input  logic     statOeN,
  output strobes_t strb
);

  logic selected;

  always_comb begin
    selected        = !cs1N && cs2;
    strb.tagWr      = selected && !tagWeN;
    strb.statWr     = selected && !statWeN;
    strb.clearAll   = !clearN;
    strb.tagDrive   = selected && !tagOeN && tagWeN;
    strb.statDrive  = selected && !statOeN && statWeN;
    strb.matchDrive = selected;
    strb.cmpEn      = selected && tagOeN && tagWeN && statWeN;
    strb.qualValid  = !modeGeneric;
  end

endmodule

// File: rtl/tag_store_datapath.sv
module tag_store_datapath
  import tag_store_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [STAT_W-1:0] statIn,
  output logic [TAG_W-1:0]  tagOut,
  output logic              tagOutEn,
  output logic [STAT_W-1:0] statOut,
  output logic              statOutEn,
  output logic              matchOut,
  output logic              matchOutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0]  tagMem [DEPTH];
  logic [DEPTH-1:0]  statPlane [STAT_W];
  logic [STAT_W-1:0] statRd;
  logic [TAG_W-1:0]  tagRd;
  logic              tagEq;

  always_ff @(posedge clk) begin
    if (strb.tagWr) tagMem[addr] <= tagIn;
  end

  // one flag plane per status bit; the clear wipes a whole plane in one edge
  for (genvar k = 0; k < STAT_W; k++) begin : g_plane
    always_ff @(posedge clk) begin
      if (strb.clearAll)    statPlane[k]       <= '0;
      else if (strb.statWr) statPlane[k][addr] <= statIn[k];
    end
    assign statRd[k] = statPlane[k][addr];
  end

  assign tagRd = tagMem[addr];
  assign tagEq = (tagRd == tagIn);

  always_comb begin
    tagOutEn   = strb.tagDrive;
    tagOut     = strb.tagDrive ? tagRd : '0;
    statOutEn  = strb.statDrive;
    statOut    = strb.statDrive ? statRd : '0;
    matchOutEn = strb.matchDrive;
    matchOut   = strb.cmpEn && tagEq && (!strb.qualValid || statRd[VLD_BIT]);
  end

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import tag_store_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              cs1N,
  input  logic              cs2,
  input  logic              modeGeneric,
  input  logic              tagWeN,
  input  logic              statWeN,
  input  logic              tagOeN,
  input  logic              statOeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [2:0]        statIn,
  output logic [TAG_W-1:0]  tagOut,
  output logic              tagOutEn,
  output logic [2:0]        statOut,
  output logic              statOutEn,
  output logic              matchOut,
  output logic              matchOutEn
);

  strobes_t strb;

  tag_store_ctrl ctrl_i (
    .clearN      (clearN),
    .cs1N        (cs1N),
    .cs2         (cs2),
    .modeGeneric (modeGeneric),
    .tagWeN      (tagWeN),
    .statWeN     (statWeN),
    .tagOeN      (tagOeN),
    .statOeN     (statOeN),
    .strb        (strb)
  );

  tag_store_datapath #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) dp_i (
    .clk        (clk),
    .strb       (strb),
    .addr       (addr),
    .tagIn      (tagIn),
    .statIn     (statIn),
    .tagOut     (tagOut),
    .tagOutEn   (tagOutEn),
    .statOut    (statOut),
    .statOutEn  (statOutEn),
    .matchOut   (matchOut),
    .matchOutEn (matchOutEn)
  );

endmodule

// File: rtl/tag_store_checker.sv
module tag_store_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              clearN,
  input logic              cs1N,
  input logic              cs2,
  input logic              tagWeN,
  input logic              statWeN,
  input logic              tagOeN,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        statOut,
  input logic              statOutEn,
  input logic              tagOutEn,
  input logic              matchOut,
  input logic              matchOutEn
);

  logic started     = 1'b0;
  logic clearedLast = 1'b0;
  logic isSel;

  assign isSel = !cs1N && cs2;

  always_ff @(posedge clk) begin
    started     <= 1'b1;
    clearedLast <= !clearN;
  end

  // R4: the first read after a clear edge sees all flags at zero
  p_clear_zeroes_status_r4: assert property (@(posedge clk) disable iff (!clearN)
    (started && clearedLast && statOutEn) |-> (statOut == 3'b000));

  // R3: a tag-only write at a held address leaves the visible flags unchanged
  p_tag_write_keeps_status_r3: assert property (@(posedge clk) disable iff (!clearN)
    (started && $past(clearN) && $past(isSel && !tagWeN && statWeN) && $stable(addr)
     && $past(statOutEn) && statOutEn) |-> $stable(statOut));

  // R5: deselected means every output is quiet
  p_deselect_quiet_r5: assert property (@(posedge clk) disable iff (!clearN)
    (cs1N || !cs2) |-> !(tagOutEn || statOutEn || matchOutEn || matchOut));

  // R7: no hit during reads or writes
  p_busy_no_match_r7: assert property (@(posedge clk) disable iff (!clearN)
    (!tagWeN || !statWeN || !tagOeN) |-> !matchOut);

endmodule

bind cache_tag_store tag_store_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .clearN     (clearN),
  .cs1N       (cs1N),
  .cs2        (cs2),
  .tagWeN     (tagWeN),
  .statWeN    (statWeN),
  .tagOeN     (tagOeN),
  .addr       (addr),
  .statOut    (statOut),
  .statOutEn  (statOutEn),
  .tagOutEn   (tagOutEn),
  .matchOut   (matchOut),
  .matchOutEn (matchOutEn)
);

// File: tb/cache_tag_store_tb_top.sv
module cache_tag_store_tb_top;

  localparam int PERIOD = 10;
  localparam int AW     = 6;
  localparam int TW     = 12;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          clearN = 1'b1, cs1N = 1'b1, cs2 = 1'b0, modeGeneric = 1'b0;
  logic          tagWeN = 1'b1, statWeN = 1'b1, tagOeN = 1'b1, statOeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] tagIn = '0;
  logic [2:0]    statIn = '0;
  logic [TW-1:0] tagOut;
  logic [2:0]    statOut;
  logic          tagOutEn, statOutEn, matchOut, matchOutEn;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  int refTag  [DEPTH];
  int refStat [DEPTH];
  bit tagKnown[DEPTH];
  bit statKnown[DEPTH];

  always #(PERIOD/2) clk = ~clk;

  cache_tag_store #(.ADDR_W(AW), .TAG_W(TW)) dut_i (
    .clk(clk), .clearN(clearN), .cs1N(cs1N), .cs2(cs2), .modeGeneric(modeGeneric),
    .tagWeN(tagWeN), .statWeN(statWeN), .tagOeN(tagOeN), .statOeN(statOeN),
    .addr(addr), .tagIn(tagIn), .statIn(statIn),
    .tagOut(tagOut), .tagOutEn(tagOutEn), .statOut(statOut), .statOutEn(statOutEn),
    .matchOut(matchOut), .matchOutEn(matchOutEn)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs against the model, then apply the edge to the model
  task automatic cyc(string req);
    bit sel, tEn, sEn, cmp, expMatch;
    int a;
    #(PERIOD/4);
    a   = int'(addr);
    sel = (cs1N == 1'b0) && (cs2 == 1'b1);
    tEn = sel && !tagOeN && tagWeN;
    sEn = sel && !statOeN && statWeN;
    cmp = sel && tagOeN && tagWeN && statWeN;
    check(req, "tagOutEn", int'(tagOutEn), int'(tEn));
    check(req, "statOutEn", int'(statOutEn), int'(sEn));
    check(req, "matchOutEn", int'(matchOutEn), int'(sel));
    if (!tEn) check(req, "tagOut idle", int'(tagOut), 0);
    else if (tagKnown[a]) check(req, "tagOut", int'(tagOut), refTag[a]);
    if (!sEn) check(req, "statOut idle", int'(statOut), 0);
    else if (statKnown[a]) check(req, "statOut", int'(statOut), refStat[a]);
    if (!cmp) check(req, "matchOut busy", int'(matchOut), 0);
    else if (tagKnown[a] && statKnown[a]) begin
      expMatch = (refTag[a] == int'(tagIn)) && (modeGeneric || refStat[a][0]);
      check(req, "matchOut", int'(matchOut), int'(expMatch));
    end
    @(posedge clk);
    if (sel && !tagWeN) begin refTag[a] = int'(tagIn); tagKnown[a] = 1'b1; end
    if (!clearN) begin
      for (int i = 0; i < DEPTH; i++) begin refStat[i] = 0; statKnown[i] = 1'b1; end
    end else if (sel && !statWeN) begin
      refStat[a] = int'(statIn); statKnown[a] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cs1N = 1'b0; cs2 = 1'b1; clearN = 1'b1;
    tagWeN = 1'b1; statWeN = 1'b1; tagOeN = 1'b1; statOeN = 1'b1;
  endtask

  task automatic readAt(string req, int a);
    idle(); addr = AW'(a); tagOeN = 1'b0; statOeN = 1'b0; cyc(req);
  endtask

  task automatic cmpAt(string req, int a, int t, bit gen);
    idle(); addr = AW'(a); tagIn = TW'(t); modeGeneric = gen; cyc(req);
  endtask

  initial begin
    @(negedge clk);
    // R4 R5: clear while deselected; reset state of the outputs
    clearN = 1'b0; cs1N = 1'b1; cs2 = 1'b0; cyc("R5");
    clearN = 1'b1; cs1N = 1'b0; cs2 = 1'b0; cyc("R5");
    // R1: fill every tag
    for (int i = 0; i < DEPTH; i++) begin
      idle(); addr = AW'(i); tagIn = TW'(i * 37 + 5); tagWeN = 1'b0; cyc("R1");
    end
    for (int i = 0; i < DEPTH; i += 9) readAt("R1", i);
    // R2: status writes and read back
    idle(); addr = 3; statIn = 3'b101; statWeN = 1'b0; cyc("R2");
    idle(); addr = 5; statIn = 3'b011; statWeN = 1'b0; statOeN = 1'b0; cyc("R9");
    readAt("R2", 3); readAt("R2", 5);
    // R3: tag write keeps flags, flag write keeps tag
    idle(); addr = 3; tagIn = 12'hABC; tagWeN = 1'b0; statOeN = 1'b0; cyc("R3");
    readAt("R3", 3);
    idle(); addr = 5; statIn = 3'b110; statWeN = 1'b0; cyc("R3");
    readAt("R3", 5);
    // R6: compare hit and miss
    cmpAt("R6", 3, 12'hABC, 1'b0);
    cmpAt("R6", 3, 12'hABD, 1'b0);
    // R8: entry 7 valid clear: dedicated misses, generic hits
    cmpAt("R8", 7, 7 * 37 + 5, 1'b0);
    cmpAt("R8", 7, 7 * 37 + 5, 1'b1);
    cmpAt("R8", 5, 12'hABC, 1'b1);
    // R7: equal tag but read or write in progress
    idle(); addr = 3; tagIn = 12'hABC; tagOeN = 1'b0; cyc("R7");
    idle(); addr = 3; tagIn = 12'hABC; statIn = 3'b101; statWeN = 1'b0; cyc("R7");
    idle(); addr = 3; tagIn = 12'hABC; tagWeN = 1'b0; cyc("R7");
    // R9: output enables held off by own write enable
    idle(); addr = 3; tagOeN = 1'b0; tagWeN = 1'b0; tagIn = 12'h123; statOeN = 1'b0; statWeN = 1'b0; statIn = 3'b001; cyc("R9");
    readAt("R9", 3);
    // R5: deselected writes are dropped
    idle(); cs2 = 1'b0; addr = 3; tagIn = 12'hFFF; tagWeN = 1'b0; statWeN = 1'b0; statIn = 3'b000; cyc("R5");
    idle(); cs1N = 1'b1; addr = 3; tagIn = 12'hFFF; tagWeN = 1'b0; cyc("R5");
    readAt("R5", 3);
    cmpAt("R6", 3, 12'h123, 1'b0);
    // R4: clear collides with a status write; clear wins, tags stay
    idle(); addr = 3; clearN = 1'b0; statIn = 3'b111; statWeN = 1'b0; cyc("R4");
    for (int i = 0; i < DEPTH; i += 5) readAt("R4", i);
    readAt("R4", 3);
    cmpAt("R4", 3, 12'h123, 1'b0);
    cmpAt("R4", 3, 12'h123, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule